// File: doc/BRIEF.md
# Block-parallel first-order IIR filter

This block runs the recursion y(n+1) = a·y(n) + u(n) on L samples per clock. Each accepted input vector carries the samples u(Lk) to u(Lk+L-1). A few clocks later the block returns the L results y(Lk+1) to y(Lk+L). The throughput is L samples per clock, while the feedback loop still closes once per clock.

Only the last lane sits in the feedback path. A look-ahead sum with the powers a^L down to a^1 maps the stored state y(Lk) straight to y(Lk+L), so the pole seen by the loop is a^L. The other L-1 results come from a chain of ordinary first-order steps. Each step uses one multiply and one add, and each starts from the result before it. The cost is therefore about 2L-1 multiply-adds per block, not L².

The coefficient `A_Q` is a Q1.15 value fixed at elaboration, and its powers are computed when the design is built. Input samples are Q1.15. Results keep 15 fractional bits and `G` extra integer bits of headroom. With `PIPE` = 1, the incremental chain is cut by a register at its midpoint, which costs one extra clock of latency.

Top module: `iirp_block_filter`

## Requirements
- R1: While rst_ni is low, and after it rises, out_valid_o is 0, y_o is 0 and the feedback state is 0. A block applied first after reset is filtered from y = 0.
- R2: Lane j of u_i (bits [j*16 +: 16]) holds u(Lk+j) as signed Q1.15. Lane i of y_o (bits [i*(16+G) +: 16+G]) holds y(Lk+i+1) as signed with 15 fractional bits. Every lane is within ±4 LSB of the exact recursion with a = A_Q/32768, for |a| ≤ 0.75.
- R3: The top lane y(Lk+L) comes from the stored y(Lk) and the L inputs through the a^L look-ahead sum. The recursion stays continuous from block to block.
- R4: Lanes 0 to L-2 are each formed from the result one position below them: a·y + u, with lane 0 starting from the stored state.
- R5: out_valid_o equals in_valid_i delayed by 1+PIPE clocks, and a result block appears only for an accepted input block.
- R6: When in_valid_i is low, the feedback state does not change and the values on u_i have no effect on later results.
- R7: y_o keeps its value on every clock where out_valid_o is low.
- R8: Full-scale constant input (±1.0) with |a| ≤ 0.75 neither wraps the look-ahead sum nor the result lanes.
- R9: The registered-midpoint variant (PIPE=1) yields the same results as the recursion, only one clock later.
- R10: A negative coefficient gives an alternating-sign response that follows the recursion in every lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input block valid |
| u_i | input | L*W | Input samples, lane j = u(Lk+j) |
| out_valid_o | output | 1 | Result block valid |
| y_o | output | L*(W+G) | Results, lane i = y(Lk+i+1) |

## Verification
On every clock, the assertions hold the valid latency and its absence for idle cycles, the frozen feedback state and output during gaps, and a lossless look-ahead sum. Whether the numbers are right can only be shown by the bench. It serializes each block into a scalar reference recursion and compares every lane. It does this for impulse, full-scale, alternating, random and gapped traffic, and through a reset in mid-stream. Two instances, with different lane counts, coefficient signs and midpoint choices, cover both chain layouts.

// File: rtl/iirp_pkg.sv
package iirp_pkg;
  // a^n in Q(fb) with a floor after each multiply
  function automatic int coef_pow(int a, int n, int fb);
    longint p;
    p = longint'(1) << fb;
    for (int i = 0; i < n; i++) p = (p * longint'(a)) >>> fb;
    return int'(p);
  endfunction
endpackage

// File: rtl/iirp_incr_step.sv
module iirp_incr_step #(
  parameter int W   = 16,
  parameter int YW  = 20,
  parameter int A_Q = 24576
) (
  input  logic signed [YW-1:0] y_prev_i,
  input  logic signed [YW-1:0] u_i,
  output logic signed [YW-1:0] y_o
);
  localparam int FB = W - 1;
  localparam int PW = YW + W + 1;
  localparam logic signed [PW-1:0] COEF = PW'(A_Q);

  logic signed [PW-1:0] prod;

  always_comb begin
    prod = PW'(y_prev_i) * COEF;
    y_o  = YW'(prod >>> FB) + u_i;
  end
endmodule

// File: rtl/iirp_loop_lane.sv
module iirp_loop_lane
  import iirp_pkg::*;
#(
  parameter int L   = 4,
  parameter int W   = 16,
  parameter int YW  = 20,
  parameter int A_Q = 24576
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic [L*W-1:0]       u_i,
  output logic signed [YW-1:0] state_o,
  output logic signed [YW-1:0] next_o
);
  localparam int FB = W - 1;
  localparam int AW = YW + W + $clog2(L) + 2;

  logic signed [AW-1:0] acc;
  logic signed [AW-1:0] full;
  logic signed [W-1:0]  u_last;

  // y(Lk+L) = a^L y(Lk) + sum a^(L-1-j) u(Lk+j)
  always_comb begin
    acc = AW'(state_o) * AW'(coef_pow(A_Q, L, FB));
    for (int j = 0; j < L - 1; j++)
      acc = acc + AW'(signed'(u_i[j*W +: W])) * AW'(coef_pow(A_Q, L - 1 - j, FB));
    u_last = signed'(u_i[(L-1)*W +: W]);
    full   = (acc >>> FB) + AW'(u_last);
    next_o = YW'(full);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      state_o <= '0;
    else if (valid_i) state_o <= next_o;
  end

  AST_STATE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(state_o)); // R6
  AST_LOOP_FITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> (full == AW'(next_o))); // R8
endmodule

// File: rtl/iirp_block_filter.sv
module iirp_block_filter #(
  parameter int L    = 4,
  parameter int W    = 16,
  parameter int G    = 4,
  parameter int A_Q  = 24576,
  parameter bit PIPE = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               in_valid_i,
  input  logic [L*W-1:0]     u_i,
  output logic               out_valid_o,
  output logic [L*(W+G)-1:0] y_o
);
  localparam int YW  = W + G;
  localparam int H   = PIPE ? L / 2 : L;  // first lane after the midpoint register
  localparam int LAT = PIPE ? 2 : 1;

  logic signed [YW-1:0] u_x   [L-1];
  logic signed [YW-1:0] y_inc [L-1];
  logic signed [YW-1:0] s1_q  [L];
  logic signed [YW-1:0] lane_v[L];
  logic signed [YW-1:0] state, loop_next;
  logic                 s1_v;
  logic [L*YW-1:0]      y_d;

  iirp_loop_lane #(.L(L), .W(W), .YW(YW), .A_Q(A_Q)) u_loop (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (in_valid_i),
    .u_i     (u_i),
    .state_o (state),
    .next_o  (loop_next)
  );

  for (genvar i = 0; i < L - 1; i++) begin : g_step
    logic signed [YW-1:0] prev, uin;
    assign u_x[i] = YW'(signed'(u_i[i*W +: W]));
    if (i == 0)      begin : g_p0 assign prev = state;       end
    else if (i == H) begin : g_pm assign prev = s1_q[H-1];   end
    else             begin : g_pn assign prev = y_inc[i-1];  end
    if (i >= H) begin : g_ur assign uin = s1_q[i]; end
    else        begin : g_ud assign uin = u_x[i];  end
    iirp_incr_step #(.W(W), .YW(YW), .A_Q(A_Q)) u_step (
      .y_prev_i (prev),
      .u_i      (uin),
      .y_o      (y_inc[i])
    );
  end

  if (PIPE) begin : g_mid
    for (genvar i = 0; i < L; i++) begin : g_lane
      logic signed [YW-1:0] d;
      if (i < H)           begin : g_y  assign d = y_inc[i];  end
      else if (i == L - 1) begin : g_lp assign d = loop_next; end
      else                 begin : g_u  assign d = u_x[i];    end
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)         s1_q[i] <= '0;
        else if (in_valid_i) s1_q[i] <= d;
      end
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) s1_v <= 1'b0;
      else         s1_v <= in_valid_i;
    end
  end else begin : g_flat
    for (genvar i = 0; i < L; i++) begin : g_lane
      if (i == L - 1) begin : g_lp assign s1_q[i] = loop_next; end
      else            begin : g_y  assign s1_q[i] = y_inc[i];  end
    end
    assign s1_v = in_valid_i;
  end

  for (genvar i = 0; i < L; i++) begin : g_out
    if (i < H || i == L - 1) begin : g_r assign lane_v[i] = s1_q[i];  end
    else                     begin : g_c assign lane_v[i] = y_inc[i]; end
  end

  always_comb
    for (int i = 0; i < L; i++) y_d[i*YW +: YW] = lane_v[i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      y_o         <= '0;
    end else begin
      out_valid_o <= s1_v;
      if (s1_v) y_o <= y_d;
    end
  end

  AST_VALID_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |-> ##LAT out_valid_o); // R5
  AST_NO_SPURIOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |-> ##LAT !out_valid_o); // R5
  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> $stable(y_o)); // R7
endmodule

// File: tb/iirp_block_filter_bench.sv
module iirp_block_filter_bench;
  localparam int W = 16, G = 4, YW = W + G;
  localparam int LA = 4, AA = 24576, LATA = 2;   // PIPE=1, a=0.75
  localparam int LB = 3, AB = -16384, LATB = 1;  // PIPE=0, a=-0.5

  logic clk = 1'b0, rst_n = 1'b0;
  logic va = 1'b0, vb = 1'b0;
  logic [LA*W-1:0] ua = '0;
  logic [LB*W-1:0] ub = '0;
  logic ova, ovb;
  logic [LA*YW-1:0] ya_o, last_a = '0;
  logic [LB*YW-1:0] yb_o, last_b = '0;

  always #4 clk = ~clk;

  iirp_block_filter #(.L(LA), .W(W), .G(G), .A_Q(AA), .PIPE(1'b1)) u_iirp_block_filter (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(va), .u_i(ua), .out_valid_o(ova), .y_o(ya_o));
  iirp_block_filter #(.L(LB), .W(W), .G(G), .A_Q(AB), .PIPE(1'b0)) u_iirp_block_filter_alt (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(vb), .u_i(ub), .out_valid_o(ovb), .y_o(yb_o));

  int  cyc = 0, n_vec = 0, n_bad = 0;
  bit  done = 1'b0;
  real ra = 0.0, rb = 0.0;
  real exa[$], exb[$];
  int  tga[$], tgb[$];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int gen(int mode, int n);
    case (mode)
      1: return (n == 0) ? 16384 : 0;
      2: return 32767;
      3: return -32768;
      4: return int'($urandom_range(65535)) - 32768;
      5: return (n % 2 == 1) ? 20000 : -20000;
      default: return 0;
    endcase
  endfunction

  // serialize each block into the scalar recursion; gaps carry garbage (R6)
  task automatic run(int mode, int nblk, int gap);
    for (int b = 0; b < nblk; b++) begin
      bit v;
      @(negedge clk);
      v = (gap == 0) || (b % gap != gap - 1);
      va = v; vb = v;
      for (int i = 0; i < LA; i++) begin
        int u;
        u = v ? gen(mode, b*LA + i) : int'($urandom_range(65535)) - 32768;
        ua[i*W +: W] = 16'(u);
        if (v) begin ra = ra * (AA / 32768.0) + u / 32768.0; exa.push_back(ra); end
      end
      for (int i = 0; i < LB; i++) begin
        int u;
        u = v ? gen(mode, b*LB + i) : int'($urandom_range(65535)) - 32768;
        ub[i*W +: W] = 16'(u);
        if (v) begin rb = rb * (AB / 32768.0) + u / 32768.0; exb.push_back(rb); end
      end
      if (v) begin tga.push_back(cyc + LATA); tgb.push_back(cyc + LATB); end
    end
    @(negedge clk);
    va = 1'b0; vb = 1'b0;
  endtask

  task automatic chk_reset();
    n_vec++;
    if (ova !== 1'b0 || ya_o !== '0) begin
      n_bad++; $display("FAIL R1 main: valid=%b y=%h exp 0/0", ova, ya_o);
    end
    n_vec++;
    if (ovb !== 1'b0 || yb_o !== '0) begin
      n_bad++; $display("FAIL R1 alt: valid=%b y=%h exp 0/0", ovb, yb_o);
    end
  endtask

  // main instance: R9 (midpoint register), lanes per R2
  always @(negedge clk) if (rst_n && !done) begin
    if (ova) begin
      n_vec++;
      if (tga.size() == 0 || tga[0] != cyc) begin
        n_bad++;
        $display("FAIL R5 main: valid at cyc %0d exp %0d", cyc, (tga.size() != 0) ? tga[0] : -1);
      end
      if (tga.size() != 0) void'(tga.pop_front());
      for (int i = 0; i < LA; i++) begin
        logic signed [YW-1:0] g;
        real e, d;
        g = ya_o[i*YW +: YW];
        e = (exa.size() != 0) ? exa.pop_front() * 32768.0 : 0.0;
        d = real'(int'(g)) - e;
        n_vec++;
        if (d > 4.0 || d < -4.0) begin
          n_bad++;
          $display("FAIL %s main lane %0d: got %0d exp %0.2f", (i == LA-1) ? "R3" : "R4", i, int'(g), e);
        end
      end
    end else begin
      n_vec++;
      if (tga.size() != 0 && tga[0] == cyc) begin
        n_bad++; $display("FAIL R5 main: valid 0 at cyc %0d exp 1", cyc);
        void'(tga.pop_front());
        for (int i = 0; i < LA; i++) if (exa.size() != 0) void'(exa.pop_front());
      end
      n_vec++;
      if (ya_o !== last_a) begin
        n_bad++; $display("FAIL R7 main: got %h exp %h", ya_o, last_a);
      end
    end
    last_a = ya_o;
  end

  // alternate instance: R10 (negative a), flat chain
  always @(negedge clk) if (rst_n && !done) begin
    if (ovb) begin
      n_vec++;
      if (tgb.size() == 0 || tgb[0] != cyc) begin
        n_bad++;
        $display("FAIL R5 alt: valid at cyc %0d exp %0d", cyc, (tgb.size() != 0) ? tgb[0] : -1);
      end
      if (tgb.size() != 0) void'(tgb.pop_front());
      for (int i = 0; i < LB; i++) begin
        logic signed [YW-1:0] g;
        real e, d;
        g = yb_o[i*YW +: YW];
        e = (exb.size() != 0) ? exb.pop_front() * 32768.0 : 0.0;
        d = real'(int'(g)) - e;
        n_vec++;
        if (d > 4.0 || d < -4.0) begin
          n_bad++;
          $display("FAIL %s alt lane %0d: got %0d exp %0.2f", (i == LB-1) ? "R3" : "R4", i, int'(g), e);
        end
      end
    end else begin
      n_vec++;
      if (tgb.size() != 0 && tgb[0] == cyc) begin
        n_bad++; $display("FAIL R5 alt: valid 0 at cyc %0d exp 1", cyc);
        void'(tgb.pop_front());
        for (int i = 0; i < LB; i++) if (exb.size() != 0) void'(exb.pop_front());
      end
      n_vec++;
      if (yb_o !== last_b) begin
        n_bad++; $display("FAIL R7 alt: got %h exp %h", yb_o, last_b);
      end
    end
    last_b = yb_o;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_reset();                   // R1
    @(negedge clk) rst_n = 1'b1;
    run(1, 8, 0);                  // impulse from zero state: R1, R3, R4
    run(0, 4, 0);
    run(2, 20, 0);                 // full scale positive: R8
    run(3, 20, 0);                 // full scale negative: R8
    run(5, 10, 0);                 // alternating, R10 on alt
    run(4, 60, 3);                 // random with gaps: R6, R7
    run(4, 40, 0);                 // random back to back: R2, R9
    repeat (4) @(negedge clk);
    rst_n = 1'b0;                  // mid-stream reset
    exa.delete(); exb.delete(); tga.delete(); tgb.delete();
    ra = 0.0; rb = 0.0; last_a = '0; last_b = '0;
    #1 chk_reset();                // R1
    @(negedge clk) rst_n = 1'b1;
    run(1, 6, 0);                  // state cleared by reset: R1
    run(4, 20, 2);
    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog: run did not complete, exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule